// File: doc/BRIEF.md
# Register-Triggered SPI EEPROM Word Reader

This block fetches one 16-bit word from a serial EEPROM on a four-wire SPI link. Software starts the fetch with a single bus write and does nothing else. One register takes the start bit and the word address. After the start, the block drives the whole SPI read frame itself. It then returns the word in the upper half of that same register and sets a done flag that software polls.

A second, read-only register reports two strap inputs: whether an EEPROM is fitted, and a 4-bit code for its capacity. When no device is fitted, a started read still completes. The done flag rises and the data reads as all ones, and the SPI pins stay idle.

Top module: `eeword_fetch`

## Requirements
- R1: After reset, the command register reads 0x00000000, `spi_cs_n` is high and `spi_sck` is low.
- R2: A read of offset 0x10 returns the present strap in bit 8 and the 4-bit size code in bits 14:11, with all other bits 0. Code 7 denotes 16 KB and code 8 denotes 32 KB. Writes to this offset change nothing.
- R3: A write to offset 0x14 with bit 0 set, made while the block is idle, starts a read of the word address carried in write bits 15:2. That address reads back in bits 15:2 of offset 0x14.
- R4: The frame has CS low, then the byte 0x03, then a 16-bit byte address equal to twice the word address, then 16 data bits, then CS high. Bits go MSB first in SPI mode 0 (SCK idle low). A frame has exactly 40 rising SCK edges.
- R5: The fetched word is placed in bits 31:16. The first byte received (even byte address) forms bits 23:16, and the second (odd byte address) forms bits 31:24.
- R6: Each SCK half period lasts CLK_DIV clocks. Done (bit 1) reads 1 from the cycle after CS returns high, which is 80*CLK_DIV+1 clock edges after the accepting edge.
- R7: A start written while a read is in progress is ignored. The address, the frame and the result all stay those of the running read.
- R8: Done reads 0 from the cycle after a start is accepted until that read completes.
- R9: With the present strap low, an accepted start sets done one cycle after the accepting edge, with data 0xFFFF and no CS activity.
- R10: A write to offset 0x14 with bit 0 clear starts nothing and leaves the address, data and done unchanged.
- R11: A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable when strobed |
| bus_addr | input | BUS_AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ee_present | input | 1 | Strap: an EEPROM is fitted |
| ee_size_code | input | 4 | Strap: encoded capacity |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Data to the EEPROM |
| spi_miso | input | 1 | Data from the EEPROM |

## Verification
The bench builds the block with CLK_DIV=2 and the full 14-bit word address. This keeps a frame at about 160 clocks, so many complete reads fit in the run. It also makes the top word address 0x3FFF, byte addresses 0x7FFE and 0x7FFF, reachable. A divider above one exercises the half-period counter variant rather than the bypass. A behavioural EEPROM answers every frame and records the opcode, address and edge count it saw, so any change to the frame, the byte order or the completion cycle shows up at the pins.

// File: rtl/eeword_pkg.sv
package eeword_pkg;

   localparam int DATA_W   = 16;
   localparam int SIZE_W   = 4;
   localparam int AFIELD_W = 14;
   localparam int OP_W     = 8;
   localparam int BADDR_W  = 16;
   localparam int FRAME_W  = OP_W + BADDR_W + DATA_W;
   localparam logic [OP_W-1:0] OP_READ = 8'h03;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SPI    = 2'd1,
      SQ_ABSENT = 2'd2
   } seq_state_t;

   function automatic logic [DATA_W-1:0] order_bytes(input logic [DATA_W-1:0] rx);
      return {rx[7:0], rx[15:8]};
   endfunction

endpackage

// File: rtl/eeword_regs.sv
module eeword_regs
   import eeword_pkg::*;
#(
   parameter int          BUS_AW   = 8,
   parameter logic [31:0] CTRL_OFS = 32'h10,
   parameter logic [31:0] READ_OFS = 32'h14,
   parameter int          WA       = 14
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ee_present,
   input  logic [SIZE_W-1:0] ee_size_code,
   input  logic              done,
   input  logic [WA-1:0]     addr_q,
   input  logic [DATA_W-1:0] data_q,
   output logic              start_req,
   output logic [WA-1:0]     start_addr
);
   localparam int PAD = AFIELD_W - WA;
   localparam logic [BUS_AW-1:0] CTRL_A = CTRL_OFS[BUS_AW-1:0];
   localparam logic [BUS_AW-1:0] READ_A = READ_OFS[BUS_AW-1:0];

   logic [AFIELD_W-1:0] afield;
   logic                unused_wdata;

   generate
      if (PAD > 0) begin : g_pad
         assign afield = {{PAD{1'b0}}, addr_q};
      end else begin : g_full
         assign afield = addr_q;
      end
   endgenerate

   assign start_req    = bus_sel & bus_we & (bus_addr == READ_A) & bus_wdata[0];
   assign start_addr   = bus_wdata[WA+1:2];
   assign unused_wdata = ^bus_wdata;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_A) begin
         bus_rdata[8]     = ee_present;
         bus_rdata[14:11] = ee_size_code;
      end else if (bus_addr == READ_A) begin
         bus_rdata = {data_q, afield, done, 1'b0};
      end
   end
endmodule

// File: rtl/eeword_spi_eng.sv
module eeword_spi_eng
   import eeword_pkg::*;
#(
   parameter int CLK_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [FRAME_W-1:0] tx_frame,
   input  logic               spi_miso,
   output logic               spi_sck,
   output logic               spi_cs_n,
   output logic               spi_mosi,
   output logic               fin,
   output logic [DATA_W-1:0]  rx_word
);
   localparam int BN_W = $clog2(FRAME_W);
   localparam logic [BN_W-1:0] LAST_BIT = BN_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] sh;
   logic [BN_W-1:0]    bitn;
   logic               tick;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(CLK_DIV);
         localparam logic [DW-1:0] DMAX = DW'(CLK_DIV - 1);
         logic [DW-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               div <= '0;
            else if (go || spi_cs_n)  div <= '0;
            else if (div == DMAX)     div <= '0;
            else                      div <= div + 1'b1;
         end
         assign tick = (div == DMAX);
      end
   endgenerate

   assign spi_mosi = sh[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_cs_n <= 1'b1;
         spi_sck  <= 1'b0;
         sh       <= '0;
         bitn     <= '0;
         fin      <= 1'b0;
         rx_word  <= '0;
      end else begin
         fin <= 1'b0;
         if (spi_cs_n) begin
            if (go) begin
               spi_cs_n <= 1'b0;
               spi_sck  <= 1'b0;
               sh       <= tx_frame;
               bitn     <= '0;
            end
         end else if (tick) begin
            if (!spi_sck) begin
               spi_sck <= 1'b1;
               rx_word <= {rx_word[DATA_W-2:0], spi_miso};
            end else begin
               spi_sck <= 1'b0;
               sh      <= {sh[FRAME_W-2:0], 1'b0};
               if (bitn == LAST_BIT) begin
                  spi_cs_n <= 1'b1;
                  fin      <= 1'b1;
               end else begin
                  bitn <= bitn + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/eeword_seq.sv
module eeword_seq
   import eeword_pkg::*;
#(
   parameter int WA = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_req,
   input  logic [WA-1:0]      start_addr,
   input  logic               ee_present,
   input  logic               fin,
   input  logic [DATA_W-1:0]  rx_word,
   output logic               go,
   output logic [FRAME_W-1:0] tx_frame,
   output logic               start_acc,
   output logic               busy,
   output logic               done,
   output logic [WA-1:0]      addr_q,
   output logic [DATA_W-1:0]  data_q
);
   seq_state_t          state;
   logic [BADDR_W-1:0]  byte_addr;

   assign start_acc = start_req & (state == SQ_IDLE);
   assign go        = start_acc & ee_present;
   assign busy      = (state != SQ_IDLE);
   assign byte_addr = BADDR_W'({start_addr, 1'b0});
   assign tx_frame  = {OP_READ, byte_addr, {DATA_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         done   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (start_acc) begin
               addr_q <= start_addr;
               done   <= 1'b0;
               state  <= ee_present ? SQ_SPI : SQ_ABSENT;
            end
            SQ_SPI: if (fin) begin
               data_q <= order_bytes(rx_word);
               done   <= 1'b1;
               state  <= SQ_IDLE;
            end
            SQ_ABSENT: begin
               data_q <= '1;
               done   <= 1'b1;
               state  <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eeword_fetch.sv
module eeword_fetch
   import eeword_pkg::*;
#(
   parameter int          BUS_AW      = 8,
   parameter logic [31:0] CTRL_OFS    = 32'h10,
   parameter logic [31:0] READ_OFS    = 32'h14,
   parameter int          WORD_ADDR_W = 14,
   parameter int          CLK_DIV     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ee_present,
   input  logic [3:0]        ee_size_code,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   initial begin : p_elab_chk
      if (WORD_ADDR_W < 1 || WORD_ADDR_W > AFIELD_W)
         $error("WORD_ADDR_W must be 1..%0d", AFIELD_W);
      if (CLK_DIV < 1)
         $error("CLK_DIV must be at least 1");
      if (CTRL_OFS[BUS_AW-1:0] == READ_OFS[BUS_AW-1:0])
         $error("register offsets collide");
   end

   logic                   start_req, start_acc, go, fin, seq_busy, done;
   logic [WORD_ADDR_W-1:0] start_addr, addr_q;
   logic [DATA_W-1:0]      data_q, rx_word;
   logic [FRAME_W-1:0]     tx_frame;

   eeword_regs #(
      .BUS_AW(BUS_AW), .CTRL_OFS(CTRL_OFS), .READ_OFS(READ_OFS), .WA(WORD_ADDR_W)
   ) u_regs (
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ee_present(ee_present), .ee_size_code(ee_size_code),
      .done(done), .addr_q(addr_q), .data_q(data_q),
      .start_req(start_req), .start_addr(start_addr)
   );

   eeword_seq #(.WA(WORD_ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_addr(start_addr),
      .ee_present(ee_present), .fin(fin), .rx_word(rx_word), .go(go),
      .tx_frame(tx_frame), .start_acc(start_acc), .busy(seq_busy),
      .done(done), .addr_q(addr_q), .data_q(data_q)
   );

   eeword_spi_eng #(.CLK_DIV(CLK_DIV)) u_spi (
      .clk(clk), .rst_n(rst_n), .go(go), .tx_frame(tx_frame),
      .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .fin(fin), .rx_word(rx_word)
   );
endmodule

// File: rtl/eeword_fetch_chk.sv
module eeword_fetch_chk #(
   parameter int WA = 14
) (
   input logic          clk,
   input logic          rst_n,
   input logic          spi_sck,
   input logic          spi_cs_n,
   input logic          ee_present,
   input logic          start_req,
   input logic          start_acc,
   input logic          busy,
   input logic          done,
   input logic [WA-1:0] addr_q,
   input logic [15:0]   data_q
);
   logic       sck_d, cs_d, acc_pres;
   logic [7:0] rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         cs_d     <= 1'b1;
         rises    <= '0;
         acc_pres <= 1'b1;
      end else begin
         sck_d <= spi_sck;
         cs_d  <= spi_cs_n;
         if (cs_d && !spi_cs_n)      rises <= '0;
         else if (!sck_d && spi_sck) rises <= rises + 1'b1;
         if (start_acc)              acc_pres <= ee_present;
      end
   end

   AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_d && spi_cs_n) |-> (rises == 8'd40)); // R4
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck); // R4
   AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> spi_cs_n); // R6
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && busy) |=> $stable(addr_q)); // R7
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_acc |=> !done); // R8
   AST_ABSENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && !acc_pres) |-> (data_q == 16'hFFFF)); // R9
   AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (start_acc && !ee_present) |=> spi_cs_n); // R9
endmodule

bind eeword_fetch eeword_fetch_chk #(.WA(WORD_ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
   .ee_present(ee_present), .start_req(start_req), .start_acc(start_acc),
   .busy(seq_busy), .done(done), .addr_q(addr_q), .data_q(data_q)
);

// File: tb/test_eeword_fetch.sv
module test_eeword_fetch;
   localparam int DIV = 2;
   localparam int WA  = 14;
   localparam logic [7:0] CT = 8'h10;
   localparam logic [7:0] RD = 8'h14;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = RD;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        ee_present = 1'b1;
   logic [3:0]  ee_size_code = 4'd7;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   int n_chk = 0, n_fail = 0;

   eeword_fetch #(.WORD_ADDR_W(WA), .CLK_DIV(DIV)) i_eeword_fetch (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ee_present(ee_present), .ee_size_code(ee_size_code),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_byte(input int a);
      return 8'((a * 37 + 11) ^ (a >> 8));
   endfunction

   // Behavioural EEPROM
   int          bits = 0, rises = 0, cs_falls = 0;
   logic [23:0] shin = '0;
   logic [7:0]  op_seen = '0;
   logic [15:0] ba_seen = '0;

   always @(negedge spi_cs_n) begin
      bits = 0; rises = 0; cs_falls++;
   end
   always @(posedge spi_sck) if (!spi_cs_n) begin
      if (bits < 24) begin
         shin = {shin[22:0], spi_mosi};
         if (bits == 23) begin
            op_seen = shin[23:16];
            ba_seen = shin[15:0];
         end
      end
      bits++; rises++;
   end
   always @(negedge spi_sck) if (!spi_cs_n && bits >= 24 && bits < 40) begin
      automatic int k = bits - 24;
      automatic logic [7:0] b = mem_byte(int'(ba_seen) + k / 8);
      spi_miso = b[7 - k % 8];
   end

   // Cycle reference model
   int          rem = 0;
   bit          done_m = 1'b0, pres_m = 1'b0;
   logic [13:0] addr_m = '0;
   logic [15:0] data_m = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         rem = 0; done_m = 0; addr_m = '0; data_m = '0; pres_m = 0;
      end else if (bus_sel && bus_we && bus_addr == RD && bus_wdata[0] && rem == 0) begin
         rem    = ee_present ? 80 * DIV + 1 : 1;
         pres_m = ee_present;
         done_m = 0;
         addr_m = bus_wdata[15:2];
      end else if (rem > 0) begin
         rem--;
         if (rem == 0) begin
            done_m = 1;
            data_m = pres_m ? {mem_byte(2*int'(addr_m)+1), mem_byte(2*int'(addr_m))} : 16'hFFFF;
         end
      end
   end

   always @(negedge clk) if (rst_n) begin
      chk("R4 cs per cycle", 32'(spi_cs_n), 32'(!(pres_m && rem >= 2)));
      if (bus_addr == RD) begin
         chk("R6/R8 done per cycle", 32'(bus_rdata[1]), 32'(done_m));
         chk("R3 addr field per cycle", 32'(bus_rdata[15:2]), 32'(addr_m));
         if (done_m) chk("R5 data per cycle", 32'(bus_rdata[31:16]), 32'(data_m));
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0; bus_addr = RD; bus_wdata = '0;
   endtask

   task automatic start_read(input logic [13:0] a);
      bus_write(RD, {16'h0, a, 2'b01});
   endtask

   task automatic wait_done;
      while (!done_m) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic read_and_check(input logic [13:0] a);
      automatic int f0 = cs_falls;
      start_read(a);
      wait_done();
      chk("R4 opcode", 32'(op_seen), 32'h03);
      chk("R4 byte address", 32'(ba_seen), 32'(2 * int'(a)));
      chk("R4 rising edges", 32'(rises), 32'd40);
      chk("R4 one frame", 32'(cs_falls), 32'(f0 + 1));
      chk("R5 word order", bus_rdata[31:16],
          32'({mem_byte(2*int'(a)+1), mem_byte(2*int'(a))}));
      chk("R3 address readback", 32'(bus_rdata[15:2]), 32'(a));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int k, f0;
      repeat (3) @(negedge clk);
      chk("R1 reset reg", bus_rdata, 32'h0);
      chk("R1 reset cs", 32'(spi_cs_n), 32'h1);
      chk("R1 reset sck", 32'(spi_sck), 32'h0);
      rst_n = 1;
      @(negedge clk);

      bus_addr = CT; #1;
      chk("R2 ctrl 16KB", bus_rdata, 32'h0000_0100 | (32'd7 << 11));
      bus_write(CT, 32'hFFFF_FFFF);
      bus_addr = CT; #1;
      chk("R2 ctrl write ignored", bus_rdata, 32'h0000_0100 | (32'd7 << 11));
      ee_size_code = 4'd8; #1;
      chk("R2 ctrl 32KB", bus_rdata, 32'h0000_0100 | (32'd8 << 11));
      bus_addr = 8'h18; #1;
      chk("R11 other offset", bus_rdata, 32'h0);
      bus_addr = 8'h00; #1;
      chk("R11 offset zero", bus_rdata, 32'h0);
      bus_addr = RD;

      read_and_check(14'h0000);
      read_and_check(14'h0005);
      read_and_check(14'h3FFF);

      // R6 completion latency and R8 clear on new start
      start_read(14'h0100);
      chk("R8 done cleared", 32'(bus_rdata[1]), 32'h0);
      k = 1;
      while (!bus_rdata[1] && k < 1000) begin @(negedge clk); k++; end
      chk("R6 latency", 32'(k), 32'(80 * DIV + 2));

      // R7 start while busy ignored
      f0 = cs_falls;
      start_read(14'h0123);
      repeat (20) @(negedge clk);
      start_read(14'h0077);
      chk("R7 addr kept", 32'(bus_rdata[15:2]), 32'h123);
      wait_done();
      chk("R7 frame address", 32'(ba_seen), 32'h246);
      chk("R7 data of first", bus_rdata[31:16], 32'({mem_byte(16'h247), mem_byte(16'h246)}));
      chk("R7 single frame", 32'(cs_falls), 32'(f0 + 1));

      // R10 write without start bit
      f0 = cs_falls;
      bus_write(RD, {16'h0, 14'h0055, 2'b00});
      repeat (5) @(negedge clk);
      chk("R10 addr unchanged", 32'(bus_rdata[15:2]), 32'h123);
      chk("R10 done kept", 32'(bus_rdata[1]), 32'h1);
      chk("R10 no frame", 32'(cs_falls), 32'(f0));

      // R9 absent device
      ee_present = 1'b0;
      f0 = cs_falls;
      start_read(14'h0042);
      chk("R9 done next cycle", 32'(bus_rdata[1]), 32'h0);
      @(negedge clk);
      chk("R9 done set", 32'(bus_rdata[1]), 32'h1);
      chk("R9 data ones", bus_rdata[31:16], 32'hFFFF);
      chk("R9 no cs activity", 32'(cs_falls), 32'(f0));
      bus_addr = CT; #1;
      chk("R2 ctrl absent", bus_rdata, 32'd8 << 11);
      bus_addr = RD;
      ee_present = 1'b1;
      read_and_check(14'h1ABC);

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule